// File: doc/BRIEF.md
# Watchdog Timer with Single or Paired Clear

This block is a watchdog timer for a small microcontroller core. A slow tick, taken from one of two tick sources, passes through a prescaler whose division is a power of two. The prescaler output advances a free-running watchdog counter. When the counter wraps past its top value, the block raises a reset request. If the core is running, the request is a full chip reset and the time-out flag is set. If the core is halted, the request is a warm reset that restarts only the program counter and the stack pointer.

Software keeps the watchdog quiet by issuing clear commands, which reach the block as one-cycle strobes. A configuration input selects one of two clearing schemes. In single mode, one general clear strobe restarts the count. In paired mode, two different clear strobes must both arrive before the count restarts. Entering halt and driving the external reset low also restart the count.

An 8-bit control register holds a 3-bit prescaler ratio code and five user flag bits. A new ratio takes effect only at the next prescaler clear.

Top module: `wdt_core`

## Requirements
- R1: After the synchronous reset `rst`, `reg_rdata` reads 8'h87 (flags 5'b10000 in bits 7..3, ratio code 3'b111 in bits 2..0). At that point `chip_rst_req`, `warm_rst_req` and `to_flag` are all 0.
- R2: With ratio code k in bits 2..0, a time-out occurs after exactly 2^WD_W x 2^k selected ticks counted from a clear. Code 0 divides by 1 and code 7 divides by 128.
- R3: Bits 7..3 of the register are written and read back unchanged. They have no effect on the timing of a time-out.
- R4: While `ext_rst_n` is low during a clock edge, the counter, the prescaler and both pending pair bits are cleared, and that edge raises no reset request.
- R5: A `halt_enter` strobe clears the counter, the prescaler and `to_flag`.
- R6: When `pair_mode` is 0, one `clr_any` strobe clears the counter and the prescaler. In this mode `clr_one` and `clr_two` have no effect.
- R7: When `pair_mode` is 1, the count restarts only once both `clr_one` and `clr_two` have arrived, in either order and any number of cycles apart. A repeated strobe of the same kind does not complete the pair. `clr_any` has no effect. An external reset discards any strobe that is still waiting for its partner.
- R8: In paired mode, `clr_one` and `clr_two` arriving in the same cycle clear the count at once.
- R9: A time-out while `halted` is 0 produces a one-cycle `chip_rst_req` pulse and sets `to_flag`. It produces no `warm_rst_req`.
- R10: A time-out while `halted` is 1 produces a one-cycle `warm_rst_req` pulse. It produces no `chip_rst_req` and leaves `to_flag` unchanged.
- R11: A write to the ratio field does not change the count in progress. The new ratio applies from the next clear.
- R12: `src_sel` = 0 counts ticks on `tick_osc` and `src_sel` = 1 counts ticks on `tick_sys`. The tick input that is not selected is ignored.
- R13: A clear in the same cycle as the counter's final tick wins. No reset request is produced, and the counter restarts from zero.
- R14: A successful software clear (R6, R7 or R8) clears `to_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_osc | input | 1 | Tick from the dedicated slow oscillator |
| tick_sys | input | 1 | Tick derived from the system clock |
| src_sel | input | 1 | Tick source select (0: tick_osc, 1: tick_sys) |
| ext_rst_n | input | 1 | External reset, active low |
| pair_mode | input | 1 | 0: single clear command, 1: paired clear commands |
| clr_any | input | 1 | Single-mode clear strobe |
| clr_one | input | 1 | First paired clear strobe |
| clr_two | input | 1 | Second paired clear strobe |
| halt_enter | input | 1 | Strobe on entry to halt |
| halted | input | 1 | Core is in halt |
| reg_we | input | 1 | Control register write enable |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| chip_rst_req | output | 1 | Full chip reset request pulse |
| warm_rst_req | output | 1 | Warm reset request pulse |
| to_flag | output | 1 | Time-out flag |

## Verification
The key collision is a clear, whether from software, halt entry or the external reset, landing in the same cycle as the tick that would wrap the counter. The bench brings the counter to one tick before the wrap and then drives that final tick together with a `clr_any` strobe in a single cycle. It judges the outcome at the ports: no reset request may appear, and a full 2^WD_W further ticks must then be needed to produce the next time-out. The checker also requires that no request follows any cycle with halt entry or the external reset asserted.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int RATIO_W = 3;
    localparam int PSC_W   = (1 << RATIO_W) - 1;
    localparam int FLAG_W  = 8 - RATIO_W;

    localparam logic [FLAG_W-1:0]  FLAG_RST  = 5'b10000;
    localparam logic [RATIO_W-1:0] RATIO_RST = 3'b111;

    typedef struct packed {
        logic [FLAG_W-1:0]  flags;
        logic [RATIO_W-1:0] ratio;
    } ctl_reg_t;

    typedef enum logic {
        SRC_OSC = 1'b0,
        SRC_SYS = 1'b1
    } tick_src_t;

    // Terminal prescaler count for a ratio code: 2^code - 1
    function automatic logic [PSC_W-1:0] psc_limit(input logic [RATIO_W-1:0] code);
        logic [PSC_W:0] one_hot;
        one_hot       = '0;
        one_hot[code] = 1'b1;
        return PSC_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/wdt_clear_ctrl.sv
module wdt_clear_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic ext_rst_n,
    input  logic pair_mode,
    input  logic clr_any,
    input  logic clr_one,
    input  logic clr_two,
    input  logic halt_enter,
    output logic sw_clr,
    output logic wipe
);
    logic pend_one, pend_two;
    logic got_one, got_two;

    always_comb begin
        got_one = pend_one | clr_one;
        got_two = pend_two | clr_two;
        sw_clr  = pair_mode ? (got_one & got_two) : clr_any;
        wipe    = sw_clr | halt_enter | ~ext_rst_n;
    end

    always_ff @(posedge clk) begin
        if (rst || !ext_rst_n || !pair_mode || sw_clr) begin
            pend_one <= 1'b0;
            pend_two <= 1'b0;
        end else begin
            pend_one <= got_one;
            pend_two <= got_two;
        end
    end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               wipe,
    input  logic [RATIO_W-1:0] ratio_req,
    output logic               pulse
);
    logic [RATIO_W-1:0] ratio_act;
    logic [PSC_W-1:0]   psc;
    logic [PSC_W-1:0]   lim;

    always_comb begin
        lim   = psc_limit(ratio_act);
        pulse = tick && !wipe && (psc == lim);
    end

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            psc       <= '0;
            ratio_act <= ratio_req;
        end else if (tick) begin
            if (psc == lim) psc <= '0;
            else            psc <= psc + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int WD_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic wipe,
    input  logic pulse,
    output logic wrap
);
    logic [WD_W-1:0] cnt;

    always_comb wrap = pulse && !wipe && (cnt == '1);

    always_ff @(posedge clk) begin
        if (rst || wipe) cnt <= '0;
        else if (pulse)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int WD_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_osc,
    input  logic       tick_sys,
    input  logic       src_sel,
    input  logic       ext_rst_n,
    input  logic       pair_mode,
    input  logic       clr_any,
    input  logic       clr_one,
    input  logic       clr_two,
    input  logic       halt_enter,
    input  logic       halted,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       chip_rst_req,
    output logic       warm_rst_req,
    output logic       to_flag
);
    ctl_reg_t ctl;
    logic     tick_sel;
    logic     sw_clr, wipe;
    logic     presc_pulse;
    logic     wrap;

    always_ff @(posedge clk) begin
        if (rst)         ctl <= '{flags: FLAG_RST, ratio: RATIO_RST};
        else if (reg_we) ctl <= ctl_reg_t'(reg_wdata);
    end
    assign reg_rdata = ctl;

    always_comb tick_sel = (tick_src_t'(src_sel) == SRC_SYS) ? tick_sys : tick_osc;

    wdt_clear_ctrl i_clear (
        .clk        (clk),
        .rst        (rst),
        .ext_rst_n  (ext_rst_n),
        .pair_mode  (pair_mode),
        .clr_any    (clr_any),
        .clr_one    (clr_one),
        .clr_two    (clr_two),
        .halt_enter (halt_enter),
        .sw_clr     (sw_clr),
        .wipe       (wipe)
    );

    wdt_prescaler i_presc (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_sel),
        .wipe      (wipe),
        .ratio_req (ctl.ratio),
        .pulse     (presc_pulse)
    );

    wdt_counter #(.WD_W(WD_W)) i_cnt (
        .clk   (clk),
        .rst   (rst),
        .wipe  (wipe),
        .pulse (presc_pulse),
        .wrap  (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chip_rst_req <= 1'b0;
            warm_rst_req <= 1'b0;
            to_flag      <= 1'b0;
        end else begin
            chip_rst_req <= wrap && !halted;
            warm_rst_req <= wrap && halted;
            if (wrap && !halted)          to_flag <= 1'b1;
            else if (sw_clr || halt_enter) to_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       ext_rst_n,
    input logic       halt_enter,
    input logic       halted,
    input logic       reg_we,
    input logic [7:0] reg_rdata,
    input logic       chip_rst_req,
    input logic       warm_rst_req,
    input logic       to_flag
);
    a_r9_chip_one_cycle: assert property (@(posedge clk) disable iff (rst)
        chip_rst_req |=> !chip_rst_req);

    a_r10_warm_one_cycle: assert property (@(posedge clk) disable iff (rst)
        warm_rst_req |=> !warm_rst_req);

    a_r9_req_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(chip_rst_req && warm_rst_req));

    a_r9_flag_with_chip: assert property (@(posedge clk) disable iff (rst)
        chip_rst_req |-> to_flag);

    a_r10_warm_only_halted: assert property (@(posedge clk) disable iff (rst)
        warm_rst_req |-> $past(halted));

    a_r4_ext_blocks_req: assert property (@(posedge clk) disable iff (rst)
        !ext_rst_n |=> (!chip_rst_req && !warm_rst_req));

    a_r5_halt_clears_flag: assert property (@(posedge clk) disable iff (rst)
        halt_enter |=> (!to_flag && !chip_rst_req && !warm_rst_req));

    a_r3_reg_holds: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> $stable(reg_rdata));
endmodule

bind wdt_core wdt_core_chk i_wdt_core_chk (
    .clk          (clk),
    .rst          (rst),
    .ext_rst_n    (ext_rst_n),
    .halt_enter   (halt_enter),
    .halted       (halted),
    .reg_we       (reg_we),
    .reg_rdata    (reg_rdata),
    .chip_rst_req (chip_rst_req),
    .warm_rst_req (warm_rst_req),
    .to_flag      (to_flag)
);

// File: tb/test_wdt_core.sv
`timescale 1ns/1ps
module test_wdt_core;
    localparam int WD_W = 8;
    localparam int FULL = 1 << WD_W;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_osc = 1'b0, tick_sys = 1'b0, src_sel = 1'b0;
    logic       ext_rst_n = 1'b1, pair_mode = 1'b0;
    logic       clr_any = 1'b0, clr_one = 1'b0, clr_two = 1'b0;
    logic       halt_enter = 1'b0, halted = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       chip_rst_req, warm_rst_req, to_flag;

    int n_checks = 0;
    int n_fail   = 0;
    int n_chip   = 0;
    int n_warm   = 0;

    always #2 clk = ~clk;

    wdt_core #(.WD_W(WD_W)) i_wdt_core (
        .clk(clk), .rst(rst), .tick_osc(tick_osc), .tick_sys(tick_sys),
        .src_sel(src_sel), .ext_rst_n(ext_rst_n), .pair_mode(pair_mode),
        .clr_any(clr_any), .clr_one(clr_one), .clr_two(clr_two),
        .halt_enter(halt_enter), .halted(halted), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chip_rst_req(chip_rst_req), .warm_rst_req(warm_rst_req),
        .to_flag(to_flag)
    );

    always @(negedge clk) begin
        if (chip_rst_req) n_chip++;
        if (warm_rst_req) n_warm++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic zero_counts();
        settle();
        n_chip = 0;
        n_warm = 0;
    endtask

    task automatic ticks(input int n, input bit on_sys = 1'b0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_osc = !on_sys;
            tick_sys = on_sys;
            @(negedge clk);
            tick_osc = 1'b0;
            tick_sys = 1'b0;
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic ext_wipe();
        @(negedge clk);
        ext_rst_n = 1'b0;
        @(negedge clk);
        ext_rst_n = 1'b1;
    endtask

    task automatic strobe(input logic s_any, input logic s_one, input logic s_two);
        @(negedge clk);
        clr_any = s_any; clr_one = s_one; clr_two = s_two;
        @(negedge clk);
        clr_any = 1'b0; clr_one = 1'b0; clr_two = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rdata", reg_rdata, 8'h87);
        check("R1 chip", chip_rst_req, 0);
        check("R1 warm", warm_rst_req, 0);
        check("R1 to_flag", to_flag, 0);
    endtask

    task automatic t_run_timeout();
        write_reg(8'h80);
        ext_wipe();
        zero_counts();
        ticks(FULL - 1);
        settle();
        check("R2 no early timeout", n_chip, 0);
        ticks(1);
        settle();
        check("R9 chip pulse count", n_chip, 1);
        check("R9 no warm", n_warm, 0);
        check("R9 to_flag set", to_flag, 1);
        strobe(1'b1, 1'b0, 1'b0);
        check("R14 to_flag cleared", to_flag, 0);
    endtask

    task automatic t_ratio();
        write_reg(8'h82);
        ext_wipe();
        zero_counts();
        ticks(FULL * 4 - 1);
        settle();
        check("R2 ratio4 early", n_chip, 0);
        ticks(1);
        settle();
        check("R2 ratio4 timeout", n_chip, 1);
    endtask

    task automatic t_flags();
        write_reg(8'hF8);
        check("R3 readback", reg_rdata, 8'hF8);
        ext_wipe();
        zero_counts();
        ticks(FULL - 1);
        settle();
        check("R3 flags no effect early", n_chip, 0);
        ticks(1);
        settle();
        check("R3 flags no effect timeout", n_chip, 1);
        check("R3 readback after", reg_rdata, 8'hF8);
        write_reg(8'h80);
    endtask

    task automatic t_single();
        pair_mode = 1'b0;
        ext_wipe();
        zero_counts();
        ticks(200);
        strobe(1'b0, 1'b1, 1'b0);
        strobe(1'b0, 1'b0, 1'b1);
        ticks(FULL - 200);
        settle();
        check("R6 paired strobes ignored", n_chip, 1);
        ext_wipe();
        zero_counts();
        ticks(200);
        strobe(1'b1, 1'b0, 1'b0);
        ticks(FULL - 1);
        settle();
        check("R6 clr_any restarts", n_chip, 0);
        ticks(1);
        settle();
        check("R6 timeout after clear", n_chip, 1);
    endtask

    task automatic t_pair();
        pair_mode = 1'b1;
        ext_wipe();
        zero_counts();
        ticks(200);
        strobe(1'b1, 1'b0, 1'b0);
        strobe(1'b0, 1'b1, 1'b0);
        strobe(1'b0, 1'b1, 1'b0);
        ticks(FULL - 200);
        settle();
        check("R7 repeat/any not a pair", n_chip, 1);
        ext_wipe();
        zero_counts();
        ticks(100);
        strobe(1'b0, 1'b0, 1'b1);
        ticks(50);
        strobe(1'b0, 1'b1, 1'b0);
        ticks(FULL - 1);
        settle();
        check("R7 reversed pair clears", n_chip, 0);
        ticks(1);
        settle();
        check("R7 timeout after pair", n_chip, 1);
        ext_wipe();
        zero_counts();
        strobe(1'b0, 1'b1, 1'b0);
        ext_wipe();
        ticks(10);
        strobe(1'b0, 1'b0, 1'b1);
        ticks(FULL - 10);
        settle();
        check("R7 ext reset drops pending", n_chip, 1);
        ext_wipe();
        zero_counts();
        ticks(200);
        strobe(1'b0, 1'b1, 1'b1);
        ticks(FULL - 1);
        settle();
        check("R8 same-cycle pair", n_chip, 0);
        ticks(1);
        settle();
        check("R8 timeout after", n_chip, 1);
        pair_mode = 1'b0;
    endtask

    task automatic t_halt();
        ext_wipe();
        zero_counts();
        ticks(FULL);
        settle();
        check("R9 flag before halt", to_flag, 1);
        zero_counts();
        ticks(100);
        @(negedge clk);
        halt_enter = 1'b1;
        @(negedge clk);
        halt_enter = 1'b0;
        halted = 1'b1;
        check("R5 halt clears to_flag", to_flag, 0);
        ticks(FULL - 1);
        settle();
        check("R5 halt restarted count", n_warm, 0);
        ticks(1);
        settle();
        check("R10 warm pulse", n_warm, 1);
        check("R10 no chip", n_chip, 0);
        check("R10 to_flag unchanged", to_flag, 0);
        halted = 1'b0;
    endtask

    task automatic t_ext();
        write_reg(8'h81);
        ext_wipe();
        zero_counts();
        ticks(301);
        ext_wipe();
        ticks(FULL * 2 - 1);
        settle();
        check("R4 ext clears count+prescaler", n_chip, 0);
        ticks(1);
        settle();
        check("R4 timeout after ext", n_chip, 1);
    endtask

    task automatic t_defer();
        write_reg(8'h80);
        ext_wipe();
        zero_counts();
        ticks(100);
        write_reg(8'h81);
        ticks(FULL - 101);
        settle();
        check("R11 old ratio early", n_chip, 0);
        ticks(1);
        settle();
        check("R11 old ratio kept", n_chip, 1);
        ext_wipe();
        zero_counts();
        ticks(FULL * 2 - 1);
        settle();
        check("R11 new ratio early", n_chip, 0);
        ticks(1);
        settle();
        check("R11 new ratio applied", n_chip, 1);
        write_reg(8'h80);
    endtask

    task automatic t_source();
        src_sel = 1'b1;
        ext_wipe();
        zero_counts();
        ticks(300, 1'b0);
        settle();
        check("R12 unselected ignored", n_chip, 0);
        ticks(FULL, 1'b1);
        settle();
        check("R12 selected counts", n_chip, 1);
        src_sel = 1'b0;
    endtask

    task automatic t_collide();
        ext_wipe();
        zero_counts();
        ticks(FULL - 1);
        @(negedge clk);
        tick_osc = 1'b1; clr_any = 1'b1;
        @(negedge clk);
        tick_osc = 1'b0; clr_any = 1'b0;
        settle();
        check("R13 clear beats wrap", n_chip, 0);
        ticks(FULL - 1);
        settle();
        check("R13 restart from zero early", n_chip, 0);
        ticks(1);
        settle();
        check("R13 timeout after restart", n_chip, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_run_timeout();
        t_ratio();
        t_flags();
        t_single();
        t_pair();
        t_halt();
        t_ext();
        t_defer();
        t_source();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule